// File: doc/BRIEF.md
# CPU Mailbox Command/Status Register

This block is one 8-bit register that a host processor uses to pass control frames and data frames between itself and a switch core. A bit position means one thing when it is written and another when it is read. When the host writes a 1 to a bit, the block sends the core a completion pulse that lasts one cycle and then clears itself. When the host reads, it gets a set of ready flags that the hardware owns. The core raises these flags through set inputs, and the host's completion writes lower them again.

The flags cover five resources: one receive control buffer, two transmit control buffers, the transmit FIFO (data available, and end of frame), and the receive FIFO (space available). One extra write bit sends a realign pulse to the receive FIFO path. This pulse is for debug only and stays 0 in normal use. A mode input turns the register off when the host interface mode selected in the system cannot use it.

The block does not include frame storage, the FIFOs, or bus decoding above the simple register port.

Top module: `cpu_mbox_csr`

## Requirements
- R1: After a synchronous active-low reset, every completion pulse output is 0, `reg_rdata` is 0x00, and every ready flag is clear, so the first read returns 0x00.
- R2: A register write is a write with `reg_wr`=1, `reg_addr`=4 and `csr_active`=1. If that write has a 1 in bit n, the matching pulse output is high in the cycle after the write edge. The bit-to-pulse map is: 0 to `rxbuf_done`, 1 to `txbuf1_done`, 2 to `txbuf2_done`, 3 to `txfifo_rxdone`, 4 to `rxfifo_last`, 5 to `rxfifo_realign`. A 0 in a bit gives no pulse.
- R3: A pulse falls back to 0 one cycle after it rises, unless a new register write sets the same bit again.
- R4: A register read is a read with `reg_rd`=1, `reg_addr`=4 and `csr_active`=1. The data of a register read appears on `reg_rdata` in the cycle after the read edge. It holds the flags as they stood before that edge, in this layout: bit 0 receive-buffer ready, bit 1 transmit-buffer-1 ready, bit 2 transmit-buffer-2 ready, bit 3 transmit-FIFO has data, bit 4 receive-FIFO has space, bit 5 transmit-FIFO end of frame. In any cycle without a register read, `reg_rdata` is 0x00.
- R5: A flag sets on the edge where its core set input is 1, and then stays set until it is cleared.
- R6: A register write with bit n=1 clears flag n for n=0..4 on the same edge that starts the pulse. Writing bit 3 also clears the end-of-frame flag (bit 5). Writing bit 5 clears no flag.
- R7: If a set input and a clear of the same flag fall on the same edge, the flag ends up set.
- R8: Bits 7:6 always read as 0. Writing them produces no pulse and changes no flag.
- R9: A write or read at any address other than 4 produces no pulse, changes no flag, and returns 0x00.
- R10: When `csr_active`=0, writes produce no pulse and clear no flag, and reads return 0x00. The flags keep following the set inputs.
- R11: A read does not change any flag. Two reads in a row with no set input and no write return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_active | input | 1 | 1 when the selected host interface mode uses this register |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write enable |
| reg_rd | input | 1 | Read enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| rxbuf_set | input | 1 | Core: receive control buffer is free |
| txbuf1_set | input | 1 | Core: transmit buffer 1 holds a frame |
| txbuf2_set | input | 1 | Core: transmit buffer 2 holds a frame |
| txfifo_set | input | 1 | Core: transmit FIFO has data |
| rxfifo_set | input | 1 | Core: receive FIFO has space |
| txeof_set | input | 1 | Core: transmit FIFO end of frame reached |
| rxbuf_done | output | 1 | Pulse: host finished writing a control frame |
| txbuf1_done | output | 1 | Pulse: host finished reading transmit buffer 1 |
| txbuf2_done | output | 1 | Pulse: host finished reading transmit buffer 2 |
| txfifo_rxdone | output | 1 | Pulse: host took a whole frame, so flush the leftovers |
| rxfifo_last | output | 1 | Pulse: the next receive-FIFO write is the last word |
| rxfifo_realign | output | 1 | Pulse: restart receive-FIFO alignment (debug) |

## Verification
Every result appears exactly one edge after the stimulus that causes it:
- A completion pulse shows up in the cycle after the write edge.
- A flag change is visible to a read issued in the next cycle.
- Read data appears in the cycle after the read edge.

The bench drives its inputs just after a rising edge and updates its own flag model at the next edge. It compares both `reg_rdata` and the pulse vector 1 ns after that edge, so each comparison lines up with the single register stage that produced the value. Directed cases come first: same-edge set and clear, a read in the same cycle as a write, reserved bits, a wrong address, and the disabled mode. A seeded random phase follows.

// File: rtl/cpu_mbox_pkg.sv
// Package: cpu_mbox_pkg
// Shared bit positions and sizes for the mailbox command/status register.
// Assumes a flag count of six; write and read views share these positions.
package cpu_mbox_pkg;
    localparam int unsigned NFLAG      = 6;
    localparam int unsigned BIT_RXBUF  = 0;
    localparam int unsigned BIT_TXBUF1 = 1;
    localparam int unsigned BIT_TXBUF2 = 2;
    localparam int unsigned BIT_TXFIFO = 3;
    localparam int unsigned BIT_RXFIFO = 4;
    localparam int unsigned BIT_AUX    = 5;  // write: realign, read: tx end of frame
endpackage

// File: rtl/mbox_decode.sv
// Module: mbox_decode
// Qualifies the register port access: an access counts only when the register
// is active and the address matches. Purely combinational.
module mbox_decode #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CSR_ADDR = 4
) (
    input  logic              csr_active,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_ADDR);

    logic sel;

    // Address and mode qualification shared by reads and writes.
    always_comb begin
        sel    = csr_active && (reg_addr == CSR_A);
        wr_hit = sel && reg_wr;
        rd_hit = sel && reg_rd;
    end
endmodule

// File: rtl/mbox_strobe_gen.sv
// Module: mbox_strobe_gen
// Turns the written 1-bits into one-cycle completion pulses toward the core.
// Assumes wr_hit is already qualified; the reserved write bits are dropped here.
module mbox_strobe_gen #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NFLAG  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [NFLAG-1:0]  wr_req,
    output logic [NFLAG-1:0]  strobe
);
    logic [DATA_W-NFLAG-1:0] rsvd_unused;

    // Reserved write bits carry no meaning.
    assign rsvd_unused = wdata[DATA_W-1:NFLAG];

    // Same-cycle request vector used by the flag bank.
    always_comb begin
        wr_req = wr_hit ? wdata[NFLAG-1:0] : '0;
    end

    // Register the requests as self-clearing pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= '0;
        else        strobe <= wr_req;
    end

    // R3: with no new write, any pulse drops on the following edge.
    p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != '0) && !wr_hit |=> strobe == '0);
endmodule

// File: rtl/mbox_flag_bank.sv
// Module: mbox_flag_bank
// Holds the hardware-owned ready flags. A flag is set by its core input and
// cleared by the matching write request; set has priority. The end-of-frame
// flag is cleared by the transmit-FIFO receive-done request.
module mbox_flag_bank #(
    parameter int unsigned NFLAG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] wr_req,
    input  logic [NFLAG-1:0] set_in,
    output logic [NFLAG-1:0] flags
);
    import cpu_mbox_pkg::*;

    logic [NFLAG-1:0] clr;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            if (i == BIT_AUX) begin : g_eof
                // End-of-frame flag consumed by the frame-done request.
                assign clr[i] = wr_req[BIT_TXFIFO];
            end else begin : g_std
                // Ordinary flag cleared by its own done request.
                assign clr[i] = wr_req[i];
            end

            // Flag register with set-over-clear priority.
            always_ff @(posedge clk) begin
                if (!rst_n)         flags[i] <= 1'b0;
                else if (set_in[i]) flags[i] <= 1'b1;
                else if (clr[i])    flags[i] <= 1'b0;
            end

            // R7: a set input always leaves the flag set.
            p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
                set_in[i] |=> flags[i]);
        end
    endgenerate
endmodule

// File: rtl/mbox_rdback.sv
// Module: mbox_rdback
// Registered read path: one cycle after a qualified read it shows the flags;
// otherwise it returns zero. Reads have no side effects.
module mbox_rdback #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NFLAG  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [NFLAG-1:0]  flags,
    output logic [DATA_W-1:0] rdata
);
    // Capture the flags on a read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_hit) rdata <= DATA_W'(flags);
        else             rdata <= '0;
    end

    // R8: reserved read bits stay zero.
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NFLAG] == '0);
endmodule

// File: rtl/cpu_mbox_csr.sv
// Module: cpu_mbox_csr
// Host mailbox command/status register: writes issue completion pulses to the
// core, reads return ready flags. Assumes a simple single-cycle register port
// and that csr_active is 0 in host modes where the register does not apply.
module cpu_mbox_csr #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CSR_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_active,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rxbuf_set,
    input  logic              txbuf1_set,
    input  logic              txbuf2_set,
    input  logic              txfifo_set,
    input  logic              rxfifo_set,
    input  logic              txeof_set,
    output logic              rxbuf_done,
    output logic              txbuf1_done,
    output logic              txbuf2_done,
    output logic              txfifo_rxdone,
    output logic              rxfifo_last,
    output logic              rxfifo_realign
);
    import cpu_mbox_pkg::*;

    logic             wr_hit, rd_hit;
    logic [NFLAG-1:0] wr_req, strobe, flags, set_in;

    // Gather the core set inputs in bit order.
    assign set_in = {txeof_set, rxfifo_set, txfifo_set, txbuf2_set, txbuf1_set, rxbuf_set};

    mbox_decode #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_dec (
        .csr_active (csr_active),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .wr_hit     (wr_hit),
        .rd_hit     (rd_hit)
    );

    mbox_strobe_gen #(.DATA_W(DATA_W), .NFLAG(NFLAG)) u_strb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (reg_wdata),
        .wr_req (wr_req),
        .strobe (strobe)
    );

    mbox_flag_bank #(.NFLAG(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .set_in (set_in),
        .flags  (flags)
    );

    mbox_rdback #(.DATA_W(DATA_W), .NFLAG(NFLAG)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_hit(rd_hit),
        .flags (flags),
        .rdata (reg_rdata)
    );

    // Fan the pulse vector out to the named core outputs.
    assign rxbuf_done     = strobe[BIT_RXBUF];
    assign txbuf1_done    = strobe[BIT_TXBUF1];
    assign txbuf2_done    = strobe[BIT_TXBUF2];
    assign txfifo_rxdone  = strobe[BIT_TXFIFO];
    assign rxfifo_last    = strobe[BIT_RXFIFO];
    assign rxfifo_realign = strobe[BIT_AUX];

    // R10: while inactive, nothing leaves the block on the next cycle.
    p_inactive_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_active |=> (strobe == '0) && (reg_rdata == '0));

    // R6: a done pulse coincides with its flag being clear unless set won.
    generate
        for (genvar i = 0; i < BIT_AUX; i++) begin : g_chk
            p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
                strobe[i] && !$past(set_in[i]) |-> !flags[i]);
        end
    endgenerate
endmodule

// File: tb/tb_cpu_mbox_csr.sv
`timescale 1ns/1ps
module tb_cpu_mbox_csr;
    logic       clk = 1'b0;
    logic       rst_n, csr_active, reg_wr, reg_rd;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [5:0] setv;
    logic rxbuf_done, txbuf1_done, txbuf2_done, txfifo_rxdone, rxfifo_last, rxfifo_realign;
    wire  [5:0] strb = {rxfifo_realign, rxfifo_last, txfifo_rxdone,
                        txbuf2_done, txbuf1_done, rxbuf_done};

    int n_vec = 0, n_bad = 0;
    logic [5:0] m_flags, m_strb;
    logic [7:0] m_rdata;
    int unsigned seed = 32'h5eed_0042;

    always #2.5 clk = ~clk;

    cpu_mbox_csr dut (
        .clk(clk), .rst_n(rst_n), .csr_active(csr_active), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rxbuf_set(setv[0]), .txbuf1_set(setv[1]), .txbuf2_set(setv[2]),
        .txfifo_set(setv[3]), .rxfifo_set(setv[4]), .txeof_set(setv[5]),
        .rxbuf_done(rxbuf_done), .txbuf1_done(txbuf1_done), .txbuf2_done(txbuf2_done),
        .txfifo_rxdone(txfifo_rxdone), .rxfifo_last(rxfifo_last),
        .rxfifo_realign(rxfifo_realign)
    );

    function automatic logic hit(input logic act, input logic en, input logic [3:0] a);
        return act && en && (a == 4'd4);
    endfunction

    // R5/R6/R7 model: bits 0..4 cleared by own write bit, bit 5 by write bit 3, set wins.
    function automatic logic [5:0] next_flags(input logic [5:0] f, input logic [5:0] s,
                                              input logic wh, input logic [7:0] wd);
        logic [5:0] clr;
        clr = '0;
        if (wh) begin
            clr[4:0] = wd[4:0];
            clr[5]   = wd[3];
        end
        return (f & ~clr) | s;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic drive(input logic act, input logic wr, input logic rd,
                         input logic [3:0] a, input logic [7:0] wd, input logic [5:0] s);
        csr_active = act; reg_wr = wr; reg_rd = rd;
        reg_addr = a; reg_wdata = wd; setv = s;
    endtask

    // One clock: predict outputs of this edge, then compare 1 ns later.
    task automatic cyc(input string tag_rd, input string tag_st);
        logic wh, rh;
        wh = hit(csr_active, reg_wr, reg_addr);
        rh = hit(csr_active, reg_rd, reg_addr);
        @(posedge clk);
        m_rdata = rh ? {2'b00, m_flags} : 8'h00;
        m_strb  = wh ? reg_wdata[5:0] : 6'h00;
        m_flags = next_flags(m_flags, setv, wh, reg_wdata);
        #1;
        check(tag_rd, reg_rdata, m_rdata);
        check(tag_st, {2'b00, strb}, {2'b00, m_strb});
    endtask

    task automatic idle_read(input string tag);
        drive(1'b1, 1'b0, 1'b1, 4'd4, 8'h00, 6'h00);
        cyc(tag, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 4'd4, 8'hff, 6'h3f);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state on outputs
        check("R1", reg_rdata, 8'h00);
        check("R1", {2'b00, strb}, 8'h00);
        drive(1'b1, 1'b0, 1'b0, 4'd4, 8'h00, 6'h00);
        m_flags = '0;
        rst_n = 1'b1;
        idle_read("R1");                       // first read after reset is 0x00

        // R5: set every flag, read it back, then again (R11: no side effect)
        drive(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 6'h3f); cyc("R5", "R5");
        idle_read("R5");
        idle_read("R11");

        // R2/R3/R6: each write bit alone
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 1'b1, 1'b0, 4'd4, 8'(1 << i), 6'h00); cyc("R6", "R2");
            drive(1'b1, 1'b0, 1'b0, 4'd4, 8'h00, 6'h00);      cyc("R3", "R3");
            idle_read("R6");
            drive(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 6'h3f);      cyc("R5", "R5");
        end

        // R7: set and clear on the same edge
        drive(1'b1, 1'b1, 1'b0, 4'd4, 8'h1f, 6'h3f); cyc("R7", "R2");
        idle_read("R7");

        // R8: reserved bits written
        drive(1'b1, 1'b1, 1'b0, 4'd4, 8'hc0, 6'h00); cyc("R8", "R8");
        idle_read("R8");

        // R9: wrong address write and read
        drive(1'b1, 1'b1, 1'b0, 4'd5, 8'h3f, 6'h00); cyc("R9", "R9");
        drive(1'b1, 1'b0, 1'b1, 4'd3, 8'h00, 6'h00); cyc("R9", "R9");
        idle_read("R9");

        // R10: inactive register
        drive(1'b0, 1'b1, 1'b0, 4'd4, 8'h3f, 6'h00); cyc("R10", "R10");
        drive(1'b0, 1'b0, 1'b1, 4'd4, 8'h00, 6'h00); cyc("R10", "R10");
        idle_read("R10");

        // R4: read in the same cycle as a clearing write returns pre-write flags
        drive(1'b1, 1'b1, 1'b1, 4'd4, 8'h0f, 6'h00); cyc("R4", "R2");
        idle_read("R4");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic act, wr, rd;
            logic [3:0] a;
            logic [5:0] s;
            act = ($urandom(seed) % 10) != 0;
            wr  = $urandom(seed) % 2;
            rd  = $urandom(seed) % 2;
            a   = (($urandom(seed) % 2) != 0) ? 4'd4 : 4'($urandom(seed));
            s   = 6'($urandom(seed) & $urandom(seed));
            drive(act, wr, rd, a, 8'($urandom(seed)), s);
            cyc("R4", "R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule